// File: doc/BRIEF.md
# Write Leveling Strobe Delay Search

This block runs the controller side of strobe-to-clock alignment during memory initialization. After a start request it puts the memory into leveling mode and switches termination to its leveling setting. It then sweeps a 7-bit strobe delay tap upward from zero. At each tap it fires one strobe pulse and waits a programmable settling time. It then reads the clock level that the memory sampled with that strobe and returned on its data lines. The first tap where the returned level goes from low to high is the alignment point, and the block reports it as the result.

Leaving and entering leveling mode are each one request/acknowledge exchange with a mode-command agent. The physical delay line follows the tap bus directly. Each feedback value is the majority of three consecutive samples, so one noisy or metastable reading does not move the result. A sweep that starts on a high level first walks forward until it sees a low level, because an edge only counts after a low reading. If the top tap passes with no edge, the block flags an error and returns the tap to zero. In every case it leaves leveling mode before it signals completion.

Top module: `strobe_align_ctrl`

## Requirements
- R1: While reset is low, and after it is released, `tap` is 0 and `mode_req`, `lvl_en`, `term_lvl`, `pulse`, `done` and `error` are all 0.
- R2: A start pulse while idle raises `mode_req`, `lvl_en` and `term_lvl` together. `mode_req` stays high until `mode_ack` is seen. `lvl_en` and `term_lvl` stay high for every cycle in which `pulse` is high.
- R3: The first strobe pulse rises on the (`enable_wait`+1)-th clock edge after the edge that accepts the entry acknowledge.
- R4: `pulse` is high for exactly one cycle. Consecutive pulses are `sample_wait`+6 cycles apart. Feedback is sampled on three consecutive edges, the first of which is `sample_wait`+2 edges after the pulse.
- R5: Each tap's feedback is the majority of its three samples. A single inverted sample out of three does not change the result.
- R6: The tap is 0 at the first pulse and rises by exactly one between consecutive pulses. It never changes by any other amount while `lvl_en` is high.
- R7: The result is the first tap whose feedback is 1 after some earlier tap read 0. High readings before the first low reading are skipped.
- R8: If tap 127 is evaluated without finding an edge, `error` is 1 when `done` rises and `tap` is 0.
- R9: On completion, `lvl_en` and `term_lvl` drop and `mode_req` is raised for exit. `done` rises for one cycle only after the exit acknowledge, and `lvl_en` and `term_lvl` are low while `done` is high.
- R10: After `done`, `tap` and `error` hold their values until the next start. A new start returns `tap` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted while idle) |
| enable_wait | input | 8 | Cycles to wait after entering leveling, before the first pulse |
| sample_wait | input | 8 | Cycles to wait after each pulse, before sampling feedback |
| mode_req | output | 1 | Request to enter leveling (`lvl_en`=1) or leave it (`lvl_en`=0) |
| mode_ack | input | 1 | Acknowledge of the mode request |
| lvl_en | output | 1 | Leveling mode active |
| term_lvl | output | 1 | Termination in its leveling setting |
| pulse | output | 1 | One-cycle strobe pulse request |
| fb | input | 1 | Sampled clock level returned on the data lines |
| tap | output | 7 | Strobe delay tap; holds the result after completion |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | No low-to-high edge was found |

## Verification
Two outcomes can fall on the same decision cycle: finding the edge and running out of taps both happen when tap 127 is evaluated. One stimulus holds the feedback low up to tap 126 and high at 127, and the bench expects a clean result of 127. A second stimulus gives a first low reading at tap 127 and never a high one, and the bench expects an error with the tap back at 0. In both runs the bench also checks the pulse count (128) and that leveling is off when `done` rises. Separate stimuli invert one sample out of every three in a fixed rhythm, which checks that the majority vote and the edge decision agree at a shifted edge.

// File: rtl/strobe_align_ctrl.sv
module strobe_align_ctrl #(
  parameter int TAP_W  = 7,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] enable_wait,
  input  logic [WAIT_W-1:0] sample_wait,
  output logic              mode_req,
  input  logic              mode_ack,
  output logic              lvl_en,
  output logic              term_lvl,
  output logic              pulse,
  input  logic              fb,
  output logic [TAP_W-1:0]  tap,
  output logic              done,
  output logic              error
);

  localparam logic [TAP_W-1:0] MAX_TAP = {TAP_W{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_ON, S_EWAIT, S_PULSE, S_SWAIT, S_SAMP, S_DEC, S_OFF, S_DONE
  } st_t;

  st_t               st;
  logic [WAIT_W-1:0] cnt;
  logic [1:0]        sidx;
  logic [2:0]        smp;
  logic              seen_lo;
  logic [TAP_W-1:0]  tap_q;
  logic              err_q;
  logic              maj;

  assign maj      = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  assign lvl_en   = (st == S_ON) || (st == S_EWAIT) || (st == S_PULSE) ||
                    (st == S_SWAIT) || (st == S_SAMP) || (st == S_DEC);
  assign term_lvl = lvl_en;
  assign mode_req = (st == S_ON) || (st == S_OFF);
  assign pulse    = (st == S_PULSE);
  assign done     = (st == S_DONE);
  assign tap      = tap_q;
  assign error    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sidx    <= '0;
      smp     <= '0;
      seen_lo <= 1'b0;
      tap_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          tap_q   <= '0;
          err_q   <= 1'b0;
          seen_lo <= 1'b0;
          st      <= S_ON;
        end
        S_ON: if (mode_ack) begin
          cnt <= enable_wait;
          st  <= S_EWAIT;
        end
        S_EWAIT: begin
          if (cnt == '0) st <= S_PULSE;
          else           cnt <= cnt - 1'b1;
        end
        S_PULSE: begin
          cnt <= sample_wait;
          st  <= S_SWAIT;
        end
        S_SWAIT: begin
          if (cnt == '0) begin
            sidx <= '0;
            st   <= S_SAMP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SAMP: begin
          smp  <= {smp[1:0], fb};
          sidx <= sidx + 1'b1;
          if (sidx == 2'd2) st <= S_DEC;
        end
        S_DEC: begin
          if (seen_lo && maj) begin
            st <= S_OFF;
          end else begin
            if (!maj) seen_lo <= 1'b1;
            if (tap_q == MAX_TAP) begin
              err_q <= 1'b1;
              tap_q <= '0;
              st    <= S_OFF;
            end else begin
              tap_q <= tap_q + 1'b1;
              st    <= S_PULSE;
            end
          end
        end
        S_OFF:  if (mode_ack) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pulse_in_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (lvl_en && term_lvl));

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  p_tap_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_en && $past(lvl_en)) |-> (tap == $past(tap) || tap == TAP_W'($past(tap) + 1'b1)));

  p_err_tap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (tap == '0));

  p_done_lvl_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!lvl_en && !term_lvl));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(tap) && $stable(error)));

endmodule

// File: tb/strobe_align_ctrl_tb.sv
`timescale 1ns/1ps
module strobe_align_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] enable_wait = '0;
  logic [7:0] sample_wait = '0;
  logic       mode_req, mode_ack = 1'b0;
  logic       lvl_en, term_lvl, pulse, done, error;
  logic       fb = 1'b0;
  logic [6:0] tap;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lo_a = 0, hi_b = 128, noisy = 0;

  always #2 clk = ~clk;

  strobe_align_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .enable_wait(enable_wait), .sample_wait(sample_wait),
    .mode_req(mode_req), .mode_ack(mode_ack),
    .lvl_en(lvl_en), .term_lvl(term_lvl), .pulse(pulse),
    .fb(fb), .tap(tap), .done(done), .error(error)
  );

  always @(posedge clk) mode_ack <= mode_req && !mode_ack;

  always @(negedge clk) begin
    automatic int t = int'(tap);
    automatic logic lv = (t < lo_a) ? 1'b1 : (t >= hi_b);
    fb  <= lv ^ (noisy != 0 && (cyc % 3) == 0);
    cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  localparam int NV = 9;
  localparam int VA [NV]  = '{0,   0,   0,  10,   0, 128,  0,  5, 127};
  localparam int VB [NV]  = '{40,  1, 127,  30, 128, 128, 55, 90, 128};
  localparam int VN [NV]  = '{0,   0,   0,   0,   0,   0,  1,  1,   0};
  localparam int VEW [NV] = '{0,   3,   1,   5,   2,   0,  4,  0,   1};
  localparam int VSW [NV] = '{0,   1,   2,   0,   3,   1,  0,  2,   0};
  localparam int VT [NV]  = '{40,  1, 127,  30,   0,   0, 55, 90,   0};
  localparam int VE [NV]  = '{0,   0,   0,   0,   1,   1,  0,  0,   1};

  task automatic run(input int i);
    int n = 0, ack_t = -1, last_p = 0, np = 0, held;
    bit got = 0;
    @(negedge clk);
    lo_a = VA[i]; hi_b = VB[i]; noisy = VN[i];
    enable_wait = 8'(VEW[i]); sample_wait = 8'(VSW[i]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tap == 7'd0, "R10 restart tap", int'(tap), 0);
    chk(mode_req && lvl_en && term_lvl, "R2 entry", int'({mode_req, lvl_en, term_lvl}), 7);
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (mode_ack && lvl_en) ack_t = n;
      if (pulse) begin
        if (np == 0) chk(n - ack_t == VEW[i] + 2, "R3 first pulse", n - ack_t, VEW[i] + 2);
        else chk(n - last_p == VSW[i] + 6, "R4 spacing", n - last_p, VSW[i] + 6);
        chk(int'(tap) == np, "R6 tap step", int'(tap), np);
        last_p = n;
        np++;
      end
      if (done) begin got = 1; break; end
    end
    chk(got, "R9 done seen", int'(got), 1);
    chk(int'(tap) == VT[i], "R5 R7 R8 result tap", int'(tap), VT[i]);
    chk(int'(error) == VE[i], "R8 error flag", int'(error), VE[i]);
    chk(!lvl_en && !term_lvl, "R9 lvl off at done", int'({lvl_en, term_lvl}), 0);
    chk(np == (VE[i] != 0 ? 128 : VT[i] + 1), "R7 pulse count", np, (VE[i] != 0 ? 128 : VT[i] + 1));
    held = int'(tap);
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(tap) == held && int'(error) == VE[i], "R10 hold", int'(tap), held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tap == 7'd0 && !mode_req && !lvl_en && !term_lvl && !pulse && !done && !error,
        "R1 in reset", int'(tap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tap == 7'd0 && !mode_req && !lvl_en && !pulse && !done && !error,
        "R1 after reset", int'({mode_req, lvl_en, pulse, done, error}), 0);

    for (int i = 0; i < NV; i++) run(i);

    @(negedge clk);
    lo_a = 0; hi_b = 100; noisy = 0; enable_wait = 8'd0; sample_wait = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    chk(lvl_en && tap != 7'd0, "R6 mid sweep", int'(tap), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tap == 7'd0 && !lvl_en && !term_lvl && !mode_req && !pulse,
        "R1 reset mid search", int'(tap), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule